// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a serially loaded 8-bit voltage DAC. An external controller sends 16-bit write frames over three wires: an active-low frame select, a serial clock and a data line. The block brings those three wires into the system clock domain and collects the bits of each frame. When a frame is complete, it loads the 8-bit conversion code and the 2-bit operating mode that drive the analog core.

A frame starts on the falling edge of the frame select. Data is taken most significant bit first on each falling edge of the serial clock. The frame takes effect on its sixteenth falling edge, where the code and the mode are loaded together and a one-cycle load strobe is raised. If the frame select rises before that edge, the partial frame is thrown away and nothing changes. A completed frame stops accepting bits until the frame select has gone high and then low again.

After reset, the code is zero and the mode is normal, so the analog output sits at 0 V until the first valid write.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `pd_mode` is 00, `pd_active` is 0 and `load_strobe` stays low until a valid frame completes.
- R2: A frame begins on a falling edge of `frm_sync_n`. While `frm_sync_n` stays low, one bit of `ser_dat` is taken on each falling edge of `ser_clk`, and the first bit taken is frame bit 15. The code is frame bits 11:4, with bit 11 as the code MSB.
- R3: The sixteenth falling edge of `ser_clk` loads the code and the mode together. `load_strobe` is high for exactly one system clock cycle for each completed frame.
- R4: If `frm_sync_n` rises before the sixteenth falling edge, the frame is discarded: the code, the mode and `pd_active` keep their values and no strobe occurs. The partially shifted bits do not leak into the next frame.
- R5: Frame bits 15:14 and 3:0 are don't-care and have no effect on any output.
- R6: Frame bits 13:12 are the mode: 00 is normal, 01 is power-down with a 1 kOhm load to ground, 10 is power-down with a 100 kOhm load to ground, and 11 is power-down with a high-impedance output. `pd_active` is 1 exactly when the loaded mode is not 00.
- R7: The code and the mode change only when a frame completes. Entering power-down and returning to normal do not clear the stored code.
- R8: Falling edges of `ser_clk` after the sixteenth one in the same low period of `frm_sync_n` are ignored. No further update occurs until `frm_sync_n` has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_sync_n | input | 1 | Active-low frame select, asynchronous to clk |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edges |
| ser_dat | input | 1 | Serial data, MSB first |
| dac_code | output | 8 | Loaded conversion code for the analog core |
| pd_mode | output | 2 | Loaded operating mode (00 normal, 01/10/11 power-down variants) |
| pd_active | output | 1 | High when the loaded mode is a power-down mode |
| load_strobe | output | 1 | One-cycle pulse when a frame is loaded |

## Verification
Some properties are checked by assertions on every cycle:
- the outputs hold between frame completions;
- the load strobe never lasts two cycles;
- the bit counter stays below the frame length;
- the frame select being high forbids any load on the following cycle;
- a completed frame disarms the receiver.

Other behaviour can only be shown by the directed scenarios:
- that the correct bits land in the code and mode fields;
- that don't-care bits are ignored;
- that an aborted frame leaves no residue in the next one;
- that trailing clock edges and a second frame sent without a select rise are rejected.

// File: rtl/sdac_pkg.sv
// Package: shared widths and mode encoding for the serial DAC frame receiver.
// Assumes the frame layout: two don't-care bits, then the mode, then the code,
// then don't-care bits to the end of the frame.
package sdac_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CODE_W     = 8;
    localparam int MODE_W     = 2;
    localparam int CODE_LSB   = 4;
    localparam int MODE_LSB   = CODE_LSB + CODE_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PD_1K  = 2'b01,
        MODE_PD_100K = 2'b10,
        MODE_PD_HIZ = 2'b11
    } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
// Module: multi-bit, multi-stage synchronizer for independent asynchronous levels.
// Assumes each bit is a slow level signal that is only sampled as a level and
// edge-detected downstream; the bits are not treated as a coherent bus.
module sdac_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture flop of the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= d_async;
            end
        end else begin : g_next
            // Purpose: further resolution stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
// Module: frame assembler. Detects edges of the synchronized frame select and
// serial clock, shifts data MSB first, and pulses commit with the full frame
// on the last falling edge. Assumes inputs are already in the clk domain and
// that each serial clock level lasts at least two clk cycles.
module sdac_shifter #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_sync_n,
    input  logic                  s_sclk,
    input  logic                  s_data,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    logic                  sync_q;
    logic                  sclk_q;
    logic                  armed;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  sync_fall;
    logic                  sclk_fall;
    logic [FRAME_BITS-1:0] shifted;

    assign sync_fall = sync_q && !s_sync_n;
    assign sclk_fall = sclk_q && !s_sclk;
    assign shifted   = {shreg[FRAME_BITS-2:0], s_data};

    // Purpose: edge history, arming, bit counting, shifting and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 1'b1;
            sclk_q  <= 1'b0;
            armed   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            frame   <= '0;
            commit  <= 1'b0;
        end else begin
            sync_q <= s_sync_n;
            sclk_q <= s_sclk;
            commit <= 1'b0;
            if (s_sync_n) begin
                armed   <= 1'b0;
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (sync_fall) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (armed && sclk_fall) begin
                shreg <= shifted;
                if (bit_cnt == LAST_IDX) begin
                    frame   <= shifted;
                    commit  <= 1'b1;
                    armed   <= 1'b0;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R8: the counter never runs past the last bit of a frame.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(FRAME_BITS));

    // R4: frame select high forbids a load on the next cycle.
    assert_abort_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_sync_n |=> !commit);

    // R8: a completed frame leaves the receiver disarmed.
    assert_disarm_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !armed);
endmodule

// File: rtl/sdac_regs.sv
// Module: holding registers for the code and mode that drive the analog core,
// plus the load strobe. Assumes commit is a single-cycle pulse carrying a
// complete, valid frame.
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [FRAME_BITS-1:0] frame,
    output logic [CODE_W-1:0]     dac_code,
    output pd_mode_e              pd_mode,
    output logic                  pd_active,
    output logic                  load_strobe
);
    logic [MODE_W-1:0] mode_field;
    assign mode_field = frame[MODE_LSB +: MODE_W];

    // Purpose: load code and mode together on commit, and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code    <= '0;
            pd_mode     <= MODE_NORMAL;
            pd_active   <= 1'b0;
            load_strobe <= 1'b0;
        end else begin
            load_strobe <= commit;
            if (commit) begin
                dac_code  <= frame[CODE_LSB +: CODE_W];
                pd_mode   <= pd_mode_e'(mode_field);
                pd_active <= |mode_field;
            end
        end
    end

    // R1: reset leaves code zero and mode normal.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && pd_mode == MODE_NORMAL && !pd_active));

    // R7: outputs only move after a commit.
    assert_hold_between_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(dac_code) && $stable(pd_mode) && $stable(pd_active)));

    // R3: the load strobe lasts exactly one cycle.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);
endmodule

// File: rtl/sdac_frame_rx.sv
// Module: top of the serial DAC frame receiver. Synchronizes the three serial
// wires to clk, assembles 16-bit frames and loads code and mode registers.
// Assumes each serial clock level lasts at least two clk cycles after
// synchronization.
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_sync_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              pd_active,
    output logic              load_strobe
);
    logic [2:0]            raw_in;
    logic [2:0]            sync_in;
    logic                  commit;
    logic [FRAME_BITS-1:0] frame;
    pd_mode_e              mode_q;

    assign raw_in = {frm_sync_n, ser_clk, ser_dat};

    sdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (sync_in)
    );

    sdac_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_sync_n (sync_in[2]),
        .s_sclk   (sync_in[1]),
        .s_data   (sync_in[0]),
        .commit   (commit),
        .frame    (frame)
    );

    sdac_regs #(
        .FRAME_BITS (FRAME_BITS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .frame       (frame),
        .dac_code    (dac_code),
        .pd_mode     (mode_q),
        .pd_active   (pd_active),
        .load_strobe (load_strobe)
    );

    assign pd_mode = mode_q;
endmodule

// File: tb/sdac_frame_rx_bench.sv
// Bench: directed scenarios for the serial DAC frame receiver.
module sdac_frame_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_sync_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [7:0] dac_code;
    logic [1:0] pd_mode;
    logic       pd_active;
    logic       load_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int strobes  = 0;
    int long_strobe = 0;
    logic strobe_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdac_frame_rx u_sdac_frame_rx (
        .clk (clk), .rst_n (rst_n), .frm_sync_n (frm_sync_n),
        .ser_clk (ser_clk), .ser_dat (ser_dat), .dac_code (dac_code),
        .pd_mode (pd_mode), .pd_active (pd_active), .load_strobe (load_strobe)
    );

    // Purpose: count strobe pulses and pulses wider than one cycle.
    always @(posedge clk) begin
        if (rst_n && load_strobe) strobes <= strobes + 1;
        if (rst_n && load_strobe && strobe_prev) long_strobe <= long_strobe + 1;
        strobe_prev <= load_strobe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of word (MSB first from bit nbits-1); optionally raise select after.
    task automatic send(input logic [31:0] word, input int nbits, input bit raise);
        frm_sync_n = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = word[i];
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        if (raise) begin
            frm_sync_n = 1'b1;
            wait_clk(8);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] mode, input logic [7:0] code);
        return {2'b00, mode, code, 4'h0};
    endfunction

    task automatic t_reset;
        chk("R1 code", dac_code, 0);
        chk("R1 mode", pd_mode, 0);
        chk("R1 pd_active", pd_active, 0);
        chk("R1 strobe count", strobes, 0);
    endtask

    task automatic t_basic_write;
        int s0 = strobes;
        send({16'h0, mk(2'b00, 8'hA5)}, 16, 1'b1);
        chk("R2 code A5", dac_code, 8'hA5);
        chk("R3 mode normal", pd_mode, 0);
        chk("R3 one strobe", strobes - s0, 1);
        send({16'h0, mk(2'b00, 8'h01)}, 16, 1'b1);
        chk("R2 code LSB", dac_code, 8'h01);
    endtask

    task automatic t_dont_care;
        send({16'h0, 2'b11, 2'b00, 8'h3C, 4'hF}, 16, 1'b1);
        chk("R5 code with junk bits", dac_code, 8'h3C);
        chk("R5 mode with junk bits", pd_mode, 0);
        chk("R5 pd_active", pd_active, 0);
    endtask

    task automatic t_abort;
        int s0 = strobes;
        send({16'h0, mk(2'b11, 8'hFF)}, 10, 1'b1);
        chk("R4 code kept", dac_code, 8'h3C);
        chk("R4 mode kept", pd_mode, 0);
        chk("R4 no strobe", strobes - s0, 0);
        send({16'h0, mk(2'b00, 8'h42)}, 16, 1'b1);
        chk("R4 clean next frame", dac_code, 8'h42);
    endtask

    task automatic t_modes;
        send({16'h0, mk(2'b01, 8'h80)}, 16, 1'b1);
        chk("R6 mode 01", pd_mode, 1);
        chk("R6 pd_active 01", pd_active, 1);
        chk("R7 code in pd", dac_code, 8'h80);
        send({16'h0, mk(2'b10, 8'h80)}, 16, 1'b1);
        chk("R6 mode 10", pd_mode, 2);
        send({16'h0, mk(2'b11, 8'h80)}, 16, 1'b1);
        chk("R6 mode 11", pd_mode, 3);
        chk("R6 pd_active 11", pd_active, 1);
        send({16'h0, mk(2'b00, 8'h80)}, 16, 1'b1);
        chk("R7 wake mode", pd_mode, 0);
        chk("R6 pd_active 00", pd_active, 0);
        chk("R7 wake code", dac_code, 8'h80);
    endtask

    task automatic t_trailing;
        int s0 = strobes;
        send({mk(2'b00, 8'hC3), 8'hFF}, 24, 1'b0);
        chk("R8 first 16 bits used", dac_code, 8'hC3);
        chk("R8 single strobe", strobes - s0, 1);
        send({16'h0, mk(2'b10, 8'h11)}, 16, 1'b1);
        chk("R8 no rearm code", dac_code, 8'hC3);
        chk("R8 no rearm mode", pd_mode, 0);
        chk("R8 no extra strobe", strobes - s0, 1);
        send({16'h0, mk(2'b00, 8'h11)}, 16, 1'b1);
        chk("R8 rearm after rise", dac_code, 8'h11);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_basic_write();
        t_dont_care();
        t_abort();
        t_modes();
        t_trailing();
        chk("R3 strobe width", long_strobe, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule